// File: doc/BRIEF.md
# Indirectly Addressed Generic Clock Controller

This block holds the configuration of a small clock distribution network. It covers a set of clock generators and a set of peripheral clock channels. Each generator stores a source selection, an enable bit and a 16-bit divide value. Each channel stores which generator feeds it and whether its clock is gated on. Software reaches all of this through four word addresses on a simple single-cycle bus. One address holds a control word. The other three are windows that are shared by every generator or every channel. The low byte of the written word names the entry that the rest of the word updates.

A full 32-bit write to a window updates the entry it names. A write that strobes only the low byte stores the ID and nothing else. The next read of that window then returns the named entry. Generator 0 feeds the main system clock, and channel 0 feeds the reference input of the frequency-locked loop. Both are brought out on dedicated ports next to the per-entry vectors.

Setting bit 0 of the control word starts a soft reset. A two-state machine moves from `ST_READY` to `ST_SWRST` for one cycle, then returns to `ST_READY`. During `ST_SWRST` every entry and every read pointer returns to its power-on value, `busy` is high, and bus writes are ignored. There are no other states or transitions. The whole block runs in one clock domain.

Top module: `gclk_indirect_ctrl`

## Requirements
- R1: After reset, generator 0 is enabled with source code 6 (8 MHz RC) and divide 0, and generator 2 is enabled with source code 3 (32 kHz ultra-low-power) and divide 0. Every other generator is disabled with source 0 and divide 0. Every channel is disabled and selects generator 0, except channel WDT_CHAN (default 3), which is enabled on generator 2. `busy` is 0.
- R2: A write with strobe 4'b1111 updates the entry named by data bits [7:0] with this layout. At address 1 (divider), bits [23:8] are the divide value. At address 2 (generator control), bits [10:8] are the source and bit 16 is the enable. At address 3 (channel control), bits [10:8] select the generator and bit 16 is the enable. The new values appear on the outputs after that clock edge.
- R3: A write to address 1, 2 or 3 with strobe 4'b0001 changes no stored entry, whatever the upper data bits hold. It sets that window's read pointer to data[7:0]. A full write also sets the pointer to its ID.
- R4: A read is registered: `bus_rdata` holds the result from the edge that samples `bus_rd`. A read of a window returns the pointed entry in the write layout, with its ID in bits [7:0] and all other bits zero.
- R5: For a stored divide value D, `gen_ratio` is 1 when D is 0 and D otherwise.
- R6: A full write whose ID is not below the number of generators (addresses 1 and 2) or channels (address 3) changes nothing. A read through a pointer holding such an ID returns 0.
- R7: A write with any strobe other than 4'b1111 or 4'b0001 to addresses 1 to 3 changes no entry and no pointer.
- R8: A write to address 0 with strobe bit 0 set and data bit 0 set moves the machine to `ST_SWRST`. `busy` is then high for exactly one cycle, after which all entries hold their R1 values and all pointers are 0. With data bit 0 clear, the write has no effect. Reading address 0 returns `busy` in bit 0.
- R9: `main_en`, `main_src` and `main_ratio` follow generator 0, and `fll_ref_en` and `fll_ref_gen` follow channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 divider, 2 generator control, 3 channel control |
| bus_strb | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | High while the soft reset is applied |
| gen_en | output | NUM_GEN | Generator enables |
| gen_src | output | NUM_GEN*SRC_W | Generator source codes |
| gen_div | output | NUM_GEN*DIV_W | Stored divide values |
| gen_ratio | output | NUM_GEN*DIV_W | Effective divide ratios |
| chan_en | output | NUM_CHAN | Channel clock enables |
| chan_gen | output | NUM_CHAN*GSEL_W | Generator selected by each channel |
| main_en | output | 1 | Main clock generator enable |
| main_src | output | SRC_W | Main clock generator source |
| main_ratio | output | DIV_W | Main clock generator ratio |
| fll_ref_en | output | 1 | Loop reference channel enable |
| fll_ref_gen | output | GSEL_W | Generator feeding the loop reference |

## Verification
The bench sweeps every generator and channel with distinct values and reads each one back through an ID-only write. A design that wrote through the ID-only strobe would corrupt entries. A design that ignored it would return the wrong entry on the read. IDs just past the end and at 255 are written with their enable bits set. A design that wraps or truncates the ID would then alter a low entry, or return nonzero data on the read-back. Partial strobes, a zero divide value (which must report a ratio of 1), and a soft reset are also covered. For the soft reset, a one-cycle `busy` pulse is checked and all defaults must be restored. A design that missed the watchdog channel or the pointers there would be caught.

// File: rtl/gclk_cfg_pkg.sv
package gclk_cfg_pkg;
    // Word addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_GEN  = 2'd2;
    localparam logic [1:0] ADDR_CHAN = 2'd3;

    // Field positions inside a window word
    localparam int ID_W       = 8;
    localparam int FIELD_LSB  = 8;
    localparam int EN_BIT     = 16;

    // Strobe patterns
    localparam logic [3:0] STRB_FULL = 4'b1111;
    localparam logic [3:0] STRB_ID   = 4'b0001;

    // Source codes used by the defaults
    localparam logic [2:0] SRC_RC8M   = 3'd6;
    localparam logic [2:0] SRC_ULP32K = 3'd3;

    // Generator indices with fixed roles
    localparam int MAIN_GEN = 0;
    localparam int ULP_GEN  = 2;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_SWRST = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/gclk_gen_bank.sv
module gclk_gen_bank
    import gclk_cfg_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     div_we,
    input  logic                     ctl_we,
    input  logic [ID_W-1:0]          id,
    input  logic [DIV_W-1:0]         div_in,
    input  logic [SRC_W-1:0]         src_in,
    input  logic                     en_in,
    output logic [NUM_GEN-1:0]       en_q,
    output logic [NUM_GEN*SRC_W-1:0] src_q,
    output logic [NUM_GEN*DIV_W-1:0] div_q,
    output logic [NUM_GEN*DIV_W-1:0] ratio
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam logic             DEF_EN  = (g == MAIN_GEN) || (g == ULP_GEN);
        localparam logic [SRC_W-1:0] DEF_SRC = (g == MAIN_GEN) ? SRC_W'(SRC_RC8M) :
                                               (g == ULP_GEN)  ? SRC_W'(SRC_ULP32K) : '0;
        logic hit;
        assign hit = (id == ID_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_q[g*DIV_W +: DIV_W] <= '0;
            end else if (clear) begin
                div_q[g*DIV_W +: DIV_W] <= '0;
            end else if (div_we && hit) begin
                div_q[g*DIV_W +: DIV_W] <= div_in;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[g]                 <= DEF_EN;
                src_q[g*SRC_W +: SRC_W] <= DEF_SRC;
            end else if (clear) begin
                en_q[g]                 <= DEF_EN;
                src_q[g*SRC_W +: SRC_W] <= DEF_SRC;
            end else if (ctl_we && hit) begin
                en_q[g]                 <= en_in;
                src_q[g*SRC_W +: SRC_W] <= src_in;
            end
        end

        assign ratio[g*DIV_W +: DIV_W] = (div_q[g*DIV_W +: DIV_W] == '0) ?
                                         DIV_W'(1) : div_q[g*DIV_W +: DIV_W];
    end
endmodule

// File: rtl/gclk_chan_bank.sv
module gclk_chan_bank
    import gclk_cfg_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int GSEL_W   = 3,
    parameter int WDT_CHAN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       we,
    input  logic [ID_W-1:0]            id,
    input  logic [GSEL_W-1:0]          gen_in,
    input  logic                       en_in,
    output logic [NUM_CHAN-1:0]        en_q,
    output logic [NUM_CHAN*GSEL_W-1:0] gen_q
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        localparam logic              DEF_EN  = (c == WDT_CHAN);
        localparam logic [GSEL_W-1:0] DEF_GEN = (c == WDT_CHAN) ? GSEL_W'(ULP_GEN) : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[c]                   <= DEF_EN;
                gen_q[c*GSEL_W +: GSEL_W] <= DEF_GEN;
            end else if (clear) begin
                en_q[c]                   <= DEF_EN;
                gen_q[c*GSEL_W +: GSEL_W] <= DEF_GEN;
            end else if (we && (id == ID_W'(c))) begin
                en_q[c]                   <= en_in;
                gen_q[c*GSEL_W +: GSEL_W] <= gen_in;
            end
        end
    end
endmodule

// File: rtl/gclk_indirect_ctrl.sv
module gclk_indirect_ctrl
    import gclk_cfg_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_CHAN = 8,
    parameter int SRC_W    = 3,
    parameter int DIV_W    = 16,
    parameter int WDT_CHAN = 3,
    localparam int GSEL_W  = $clog2(NUM_GEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [1:0]                 bus_addr,
    input  logic [3:0]                 bus_strb,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       busy,
    output logic [NUM_GEN-1:0]         gen_en,
    output logic [NUM_GEN*SRC_W-1:0]   gen_src,
    output logic [NUM_GEN*DIV_W-1:0]   gen_div,
    output logic [NUM_GEN*DIV_W-1:0]   gen_ratio,
    output logic [NUM_CHAN-1:0]        chan_en,
    output logic [NUM_CHAN*GSEL_W-1:0] chan_gen,
    output logic                       main_en,
    output logic [SRC_W-1:0]           main_src,
    output logic [DIV_W-1:0]           main_ratio,
    output logic                       fll_ref_en,
    output logic [GSEL_W-1:0]          fll_ref_gen
);
    ctl_state_e state_q, state_d;
    logic       clear;

    logic            wr_ok, strb_full, strb_id, swrst_req;
    logic [ID_W-1:0] wid;
    logic            div_we, gen_we, chan_we;
    logic [ID_W-1:0] ptr_div, ptr_gen, ptr_chan;
    logic [31:0]     rd_next;

    assign wid       = bus_wdata[ID_W-1:0];
    assign strb_full = (bus_strb == STRB_FULL);
    assign strb_id   = (bus_strb == STRB_ID);
    assign wr_ok     = bus_wr && (state_q == ST_READY);
    assign swrst_req = wr_ok && (bus_addr == ADDR_CTRL) && bus_strb[0] && bus_wdata[0];

    assign div_we  = wr_ok && strb_full && (bus_addr == ADDR_DIV)  && (wid < ID_W'(NUM_GEN));
    assign gen_we  = wr_ok && strb_full && (bus_addr == ADDR_GEN)  && (wid < ID_W'(NUM_GEN));
    assign chan_we = wr_ok && strb_full && (bus_addr == ADDR_CHAN) && (wid < ID_W'(NUM_CHAN));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (swrst_req) state_d = ST_SWRST;
            ST_SWRST: state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SWRST: clear = 1'b1;
            default:  clear = 1'b0;
        endcase
    end
    assign busy = clear;

    // Read pointers, one per window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_div  <= '0;
            ptr_gen  <= '0;
            ptr_chan <= '0;
        end else if (clear) begin
            ptr_div  <= '0;
            ptr_gen  <= '0;
            ptr_chan <= '0;
        end else if (wr_ok && (strb_full || strb_id)) begin
            case (bus_addr)
                ADDR_DIV:  ptr_div  <= wid;
                ADDR_GEN:  ptr_gen  <= wid;
                ADDR_CHAN: ptr_chan <= wid;
                default:   ;
            endcase
        end
    end

    gclk_gen_bank #(
        .NUM_GEN (NUM_GEN),
        .SRC_W   (SRC_W),
        .DIV_W   (DIV_W)
    ) gen_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .div_we (div_we),
        .ctl_we (gen_we),
        .id     (wid),
        .div_in (bus_wdata[FIELD_LSB +: DIV_W]),
        .src_in (bus_wdata[FIELD_LSB +: SRC_W]),
        .en_in  (bus_wdata[EN_BIT]),
        .en_q   (gen_en),
        .src_q  (gen_src),
        .div_q  (gen_div),
        .ratio  (gen_ratio)
    );

    gclk_chan_bank #(
        .NUM_CHAN (NUM_CHAN),
        .GSEL_W   (GSEL_W),
        .WDT_CHAN (WDT_CHAN)
    ) chan_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .we     (chan_we),
        .id     (wid),
        .gen_in (bus_wdata[FIELD_LSB +: GSEL_W]),
        .en_in  (bus_wdata[EN_BIT]),
        .en_q   (chan_en),
        .gen_q  (chan_gen)
    );

    // Read multiplexer
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            ADDR_CTRL: rd_next[0] = busy;
            ADDR_DIV: begin
                for (int g = 0; g < NUM_GEN; g++) begin
                    if (ptr_div == ID_W'(g)) begin
                        rd_next[ID_W-1:0]            = ptr_div;
                        rd_next[FIELD_LSB +: DIV_W]  = gen_div[g*DIV_W +: DIV_W];
                    end
                end
            end
            ADDR_GEN: begin
                for (int g = 0; g < NUM_GEN; g++) begin
                    if (ptr_gen == ID_W'(g)) begin
                        rd_next[ID_W-1:0]            = ptr_gen;
                        rd_next[FIELD_LSB +: SRC_W]  = gen_src[g*SRC_W +: SRC_W];
                        rd_next[EN_BIT]              = gen_en[g];
                    end
                end
            end
            default: begin
                for (int c = 0; c < NUM_CHAN; c++) begin
                    if (ptr_chan == ID_W'(c)) begin
                        rd_next[ID_W-1:0]            = ptr_chan;
                        rd_next[FIELD_LSB +: GSEL_W] = chan_gen[c*GSEL_W +: GSEL_W];
                        rd_next[EN_BIT]              = chan_en[c];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // Dedicated roles
    assign main_en     = gen_en[MAIN_GEN];
    assign main_src    = gen_src[MAIN_GEN*SRC_W +: SRC_W];
    assign main_ratio  = gen_ratio[MAIN_GEN*DIV_W +: DIV_W];
    assign fll_ref_en  = chan_en[0];
    assign fll_ref_gen = chan_gen[GSEL_W-1:0];
endmodule

// File: rtl/gclk_indirect_ctrl_chk.sv
module gclk_indirect_ctrl_chk
    import gclk_cfg_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_CHAN = 8,
    parameter int SRC_W    = 3,
    parameter int DIV_W    = 16,
    parameter int WDT_CHAN = 3,
    parameter int GSEL_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [1:0]                 bus_addr,
    input logic [3:0]                 bus_strb,
    input logic [31:0]                bus_wdata,
    input logic                       busy,
    input logic [NUM_GEN-1:0]         gen_en,
    input logic [NUM_GEN*SRC_W-1:0]   gen_src,
    input logic [NUM_GEN*DIV_W-1:0]   gen_div,
    input logic [NUM_CHAN-1:0]        chan_en,
    input logic [NUM_CHAN*GSEL_W-1:0] chan_gen,
    input logic                       main_en,
    input logic [DIV_W-1:0]           main_ratio
);
    localparam logic [NUM_GEN-1:0]  DEF_GEN_EN  = NUM_GEN'((1 << MAIN_GEN) | (1 << ULP_GEN));
    localparam logic [NUM_CHAN-1:0] DEF_CHAN_EN = NUM_CHAN'(1 << WDT_CHAN);

    // R8
    swrst_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == ADDR_CTRL && bus_strb[0] && bus_wdata[0]) |=> busy);

    // R8
    busy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R1
    swrst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (gen_en == DEF_GEN_EN && chan_en == DEF_CHAN_EN));

    // R3
    id_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr != ADDR_CTRL && bus_strb == STRB_ID) |=>
        ($stable(gen_en) && $stable(gen_src) && $stable(gen_div) &&
         $stable(chan_en) && $stable(chan_gen)));

    // R6
    oor_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == ADDR_GEN &&
         bus_wdata[ID_W-1:0] >= ID_W'(NUM_GEN)) |=> ($stable(gen_en) && $stable(gen_src)));

    // R2
    main_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == ADDR_GEN && bus_strb == STRB_FULL &&
         bus_wdata[ID_W-1:0] == '0) |=> (main_en == $past(bus_wdata[EN_BIT])));

    // R5
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_ratio != '0);
endmodule

bind gclk_indirect_ctrl gclk_indirect_ctrl_chk #(
    .NUM_GEN  (NUM_GEN),
    .NUM_CHAN (NUM_CHAN),
    .SRC_W    (SRC_W),
    .DIV_W    (DIV_W),
    .WDT_CHAN (WDT_CHAN),
    .GSEL_W   (GSEL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_strb   (bus_strb),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .gen_en     (gen_en),
    .gen_src    (gen_src),
    .gen_div    (gen_div),
    .chan_en    (chan_en),
    .chan_gen   (chan_gen),
    .main_en    (main_en),
    .main_ratio (main_ratio)
);

// File: tb/gclk_indirect_ctrl_tb_top.sv
module gclk_indirect_ctrl_tb_top;
    localparam int NG = 8;
    localparam int NC = 8;
    localparam int SW = 3;
    localparam int DW = 16;
    localparam int WDT = 3;
    localparam int GW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic [3:0]      bus_strb = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            busy;
    logic [NG-1:0]   gen_en;
    logic [NG*SW-1:0] gen_src;
    logic [NG*DW-1:0] gen_div, gen_ratio;
    logic [NC-1:0]   chan_en;
    logic [NC*GW-1:0] chan_gen;
    logic            main_en, fll_ref_en;
    logic [SW-1:0]   main_src;
    logic [DW-1:0]   main_ratio;
    logic [GW-1:0]   fll_ref_gen;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] e_div [NG];
    logic [SW-1:0] e_src [NG];
    logic          e_gen_en [NG];
    logic [GW-1:0] e_cg [NC];
    logic          e_ce [NC];

    always #5 clk = ~clk;

    gclk_indirect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy), .gen_en(gen_en), .gen_src(gen_src),
        .gen_div(gen_div), .gen_ratio(gen_ratio), .chan_en(chan_en),
        .chan_gen(chan_gen), .main_en(main_en), .main_src(main_src),
        .main_ratio(main_ratio), .fll_ref_en(fll_ref_en), .fll_ref_gen(fll_ref_gen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_strb = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_strb = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_defaults();
        for (int g = 0; g < NG; g++) begin
            e_div[g] = '0; e_src[g] = '0; e_gen_en[g] = 1'b0;
        end
        e_gen_en[0] = 1'b1; e_src[0] = 3'd6;
        e_gen_en[2] = 1'b1; e_src[2] = 3'd3;
        for (int c = 0; c < NC; c++) begin
            e_cg[c] = '0; e_ce[c] = 1'b0;
        end
        e_ce[WDT] = 1'b1; e_cg[WDT] = 3'd2;
    endtask

    task automatic chk_outputs(input string req);
        for (int g = 0; g < NG; g++) begin
            chk(req, 32'(gen_en[g]), 32'(e_gen_en[g]));
            chk(req, 32'(gen_src[g*SW +: SW]), 32'(e_src[g]));
            chk(req, 32'(gen_div[g*DW +: DW]), 32'(e_div[g]));
            chk("R5", 32'(gen_ratio[g*DW +: DW]), (e_div[g] == 0) ? 32'd1 : 32'(e_div[g]));
        end
        for (int c = 0; c < NC; c++) begin
            chk(req, 32'(chan_en[c]), 32'(e_ce[c]));
            chk(req, 32'(chan_gen[c*GW +: GW]), 32'(e_cg[c]));
        end
        chk("R9", {main_en, main_src, main_ratio},
            {e_gen_en[0], e_src[0], (e_div[0] == 0) ? 16'd1 : e_div[0]});
        chk("R9", {fll_ref_en, fll_ref_gen}, {e_ce[0], e_cg[0]});
    endtask

    task automatic chk_readback(input string req);
        logic [31:0] d;
        for (int g = 0; g < NG; g++) begin
            wr(2'd1, 4'b0001, 32'(g));
            rd(2'd1, d);
            chk(req, d, {8'h0, e_div[g], 8'(g)});
            wr(2'd2, 4'b0001, 32'(g));
            rd(2'd2, d);
            chk(req, d, (32'(e_gen_en[g]) << 16) | (32'(e_src[g]) << 8) | 32'(g));
        end
        for (int c = 0; c < NC; c++) begin
            wr(2'd3, 4'b0001, 32'(c));
            rd(2'd3, d);
            chk(req, d, (32'(e_ce[c]) << 16) | (32'(e_cg[c]) << 8) | 32'(c));
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        set_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", 32'(busy), 32'd0);
        chk_outputs("R1");
        chk_readback("R4");

        // R2 sweep generators
        for (int g = 0; g < NG; g++) begin
            e_div[g]    = (g == 3) ? 16'd0 : 16'(g * 4099 + 17);
            e_src[g]    = 3'((g + 5) % 8);
            e_gen_en[g] = (g % 2) == 1;
            wr(2'd1, 4'b1111, {8'h0, e_div[g], 8'(g)});
            wr(2'd2, 4'b1111, (32'(e_gen_en[g]) << 16) | (32'(e_src[g]) << 8) | 32'(g));
        end
        chk_outputs("R2");

        // R2 sweep channels
        for (int c = 0; c < NC; c++) begin
            e_cg[c] = 3'((c * 3 + 1) % 8);
            e_ce[c] = (c % 2) == 0;
            wr(2'd3, 4'b1111, (32'(e_ce[c]) << 16) | (32'(e_cg[c]) << 8) | 32'(c));
        end
        chk_outputs("R2");
        chk_readback("R3");

        // R3 ID-only writes with noisy upper bytes
        wr(2'd1, 4'b0001, 32'hFFFF_FF01);
        wr(2'd2, 4'b0001, 32'hFFFF_FF00);
        wr(2'd3, 4'b0001, 32'hFFFF_FF02);
        chk_outputs("R3");
        rd(2'd2, d);
        chk("R3", d, (32'(e_gen_en[0]) << 16) | (32'(e_src[0]) << 8));

        // R6 out-of-range IDs
        wr(2'd1, 4'b1111, 32'h00FF_FF08);
        wr(2'd2, 4'b1111, 32'h0001_07C8);
        wr(2'd3, 4'b1111, 32'h0001_07FF);
        chk_outputs("R6");
        rd(2'd1, d); chk("R6", d, 32'd0);
        rd(2'd2, d); chk("R6", d, 32'd0);
        rd(2'd3, d); chk("R6", d, 32'd0);

        // R7 partial strobes
        wr(2'd2, 4'b0011, 32'h0001_0700);
        wr(2'd1, 4'b1110, 32'h00AB_CD01);
        wr(2'd3, 4'b0111, 32'h0001_0705);
        chk_outputs("R7");
        rd(2'd2, d); chk("R7", d, 32'd0);

        // R8 control write with bit 0 clear has no effect
        wr(2'd0, 4'b1111, 32'hFFFF_FFFE);
        chk("R8", 32'(busy), 32'd0);
        chk_outputs("R8");

        // R8 soft reset
        wr(2'd0, 4'b0001, 32'h0000_0001);
        chk("R8", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R8", 32'(busy), 32'd0);
        set_defaults();
        chk_outputs("R8");
        rd(2'd0, d); chk("R8", d, 32'd0);
        rd(2'd1, d); chk("R8", d, 32'd0);
        rd(2'd3, d); chk("R8", d, 32'd0);
        chk_readback("R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule